// File: doc/BRIEF.md
# Self-Seeding Pseudo-Random Bit Stream Checker

This block watches a received serial bit stream that a 7-stage maximal-length linear feedback generator produced. It holds its own 7-stage generator. It needs neither the transmitter's starting state nor the delay of the link. While unlocked, it opens its feedback loop and shifts each received bit straight into the local register. Once the register holds seven received bits, and provided they are not all zero, it closes the loop. From then on the local register runs on its own feedback. Each later received bit is then compared with the bit the register predicts.

The checker reports three things: a lock flag, a one-cycle error strobe and a saturating error count. If errors crowd together within a sliding window of checked bits, it assumes it has lost track of the stream. It then drops lock and seeds itself again from the incoming bits. The error count is kept across this re-seeding. Every state change is qualified by a bit-valid input, so the stream may contain gaps.

Top module: `prbs_seed_checker`

## Requirements
- R1: A synchronous, active-high reset clears the lock flag, the error strobe and the error count to zero.
- R2: While unlocked, each valid bit shifts into stage 1 of the local register; stage 1 holds the newest bit and stage 7 the oldest. The lock flag is still low after the sixth valid bit. It is high after the clock edge that takes the seventh valid bit, provided the seeded register is non-zero.
- R3: Once locked, the predicted bit is the XOR of stages 7 and 6, and the register shifts that bit into stage 1. A stream from the generator x^7 + x^6 + 1 yields no errors, whichever of its 127 phases it starts from.
- R4: The error strobe is high for exactly the one cycle that follows the edge taking a valid, locked bit that differs from the prediction. It stays low for matching bits and while unlocked.
- R5: The error count rises by one for each strobed error. It holds at its all-ones maximum of CNT_W bits and does not wrap; the strobe still pulses at that maximum.
- R6: On an edge where bit-valid is low, the received bit is ignored. Lock, seeding progress, the local register and the count all stay unchanged, and no strobe follows.
- R7: If ERR_LIMIT (8) errors fall within any WIN_LEN (127) consecutive checked bits, the lock flag drops on the edge of the error that reaches the limit. Seeding then restarts with the next valid bit, and seven more bits lock again. Errors spaced 19 bits apart never drop lock; errors spaced 18 apart drop it at the eighth.
- R8: Dropping lock and re-seeding leaves the error count unchanged.
- R9: If seven seeded bits are all zero, the lock flag stays low and seeding continues one bit at a time. It locks on the first valid bit that makes the last seven bits non-zero.
- R10: An errored received bit does not disturb the local register, so the bit after an isolated error is checked correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxBit | input | 1 | Received data bit |
| rxValid | input | 1 | High when rxBit carries a bit this cycle |
| lockFlag | output | 1 | High while the local generator tracks the stream |
| errStrobe | output | 1 | One-cycle pulse per mismatched checked bit |
| errCount | output | CNT_W | Saturating count of mismatched bits |

## Verification
Every output of this block is a register, so each result shows up one cycle after the rising edge that samples the valid bit. The lock flag reflects the seventh seeding bit one cycle later. The strobe and the count reflect a mismatch one cycle later. A lock drop shows up on the same cycle as the strobe for the error that hits the limit. The bench changes inputs on the falling edge and reads outputs 2 ns after the rising edge that takes each bit. Every expected value therefore belongs to exactly one driven bit. The expected values come from a generator model kept in the bench and from arithmetic on error positions. They cover all 127 start phases, error spacings either side of the window limit, and a run past the count maximum.

// File: rtl/plc_pkg.sv
package plc_pkg;
  // Strobes from control to datapath and window, one set per clock edge
  typedef struct packed {
    logic seedShift;  // open loop: shift received bit into the register
    logic checkBit;   // closed loop: compare, count, advance on feedback
  } plcCtrl_t;
endpackage

// File: rtl/plc_datapath.sv
module plc_datapath
  import plc_pkg::*;
#(
  parameter int LFSR_LEN = 7,
  parameter int TAP_HI   = 7,
  parameter int TAP_LO   = 6,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxBit,
  input  plcCtrl_t         ctrl,
  output logic             mismatch,
  output logic             seedNonZero,
  output logic             errStrobe,
  output logic [CNT_W-1:0] errCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [LFSR_LEN-1:0] genState;
  logic                fbBit;

  // Stage 1 is bit 0 (newest), stage LFSR_LEN is the top bit (oldest)
  assign fbBit       = genState[TAP_HI-1] ^ genState[TAP_LO-1];
  assign mismatch    = ctrl.checkBit && (rxBit != fbBit);
  assign seedNonZero = ({genState[LFSR_LEN-2:0], rxBit} != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      genState <= '0;
    end else if (ctrl.seedShift) begin
      genState <= {genState[LFSR_LEN-2:0], rxBit};
    end else if (ctrl.checkBit) begin
      genState <= {genState[LFSR_LEN-2:0], fbBit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errStrobe <= 1'b0;
    end else begin
      errStrobe <= mismatch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errCount <= '0;
    end else if (mismatch && (errCount != CNT_MAX)) begin
      errCount <= errCount + CNT_W'(1);
    end
  end
endmodule

// File: rtl/plc_window.sv
module plc_window
  import plc_pkg::*;
#(
  parameter int WIN_LEN   = 127,
  parameter int ERR_LIMIT = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  plcCtrl_t ctrl,
  input  logic     mismatch,
  output logic     limitHit
);
  localparam int WIN_CW = $clog2(WIN_LEN + 1);

  logic [WIN_LEN-1:0] errHist;
  logic [WIN_CW-1:0]  winErrs;
  logic [WIN_CW-1:0]  nextErrs;
  logic               flushHist;

  // History is flushed whenever seeding runs, so a fresh lock starts clean
  assign flushHist = rst || ctrl.seedShift;
  assign nextErrs  = winErrs + WIN_CW'(mismatch) - WIN_CW'(errHist[WIN_LEN-1]);
  assign limitHit  = ctrl.checkBit && (nextErrs >= WIN_CW'(ERR_LIMIT));

  always_ff @(posedge clk) begin
    if (flushHist) begin
      errHist[0] <= 1'b0;
    end else if (ctrl.checkBit) begin
      errHist[0] <= mismatch;
    end
  end

  for (genvar gi = 1; gi < WIN_LEN; gi++) begin : g_hist
    always_ff @(posedge clk) begin
      if (flushHist) begin
        errHist[gi] <= 1'b0;
      end else if (ctrl.checkBit) begin
        errHist[gi] <= errHist[gi-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (flushHist) begin
      winErrs <= '0;
    end else if (ctrl.checkBit) begin
      winErrs <= nextErrs;
    end
  end
endmodule

// File: rtl/plc_control.sv
module plc_control
  import plc_pkg::*;
#(
  parameter int LFSR_LEN = 7
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     rxValid,
  input  logic     seedNonZero,
  input  logic     limitHit,
  output plcCtrl_t ctrl,
  output logic     lockFlag
);
  localparam int SEED_CW = $clog2(LFSR_LEN + 1);
  localparam logic [SEED_CW-1:0] SEED_LAST = SEED_CW'(LFSR_LEN - 1);
  localparam logic [SEED_CW-1:0] SEED_FULL = SEED_CW'(LFSR_LEN);

  logic [SEED_CW-1:0] seedCnt;
  logic               seedDone;

  // This bit fills the register (or it is already full and waiting on non-zero)
  assign seedDone = (seedCnt >= SEED_LAST);

  always_comb begin
    ctrl.seedShift = rxValid && !lockFlag;
    ctrl.checkBit  = rxValid && lockFlag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seedCnt  <= '0;
      lockFlag <= 1'b0;
    end else if (ctrl.seedShift) begin
      if (seedCnt != SEED_FULL) begin
        seedCnt <= seedCnt + SEED_CW'(1);
      end
      if (seedDone && seedNonZero) begin
        lockFlag <= 1'b1;
      end
    end else if (limitHit) begin
      lockFlag <= 1'b0;
      seedCnt  <= '0;
    end
  end
endmodule

// File: rtl/prbs_seed_checker.sv
module prbs_seed_checker
  import plc_pkg::*;
#(
  parameter int LFSR_LEN  = 7,
  parameter int TAP_HI    = 7,
  parameter int TAP_LO    = 6,
  parameter int CNT_W     = 16,
  parameter int WIN_LEN   = 127,
  parameter int ERR_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxBit,
  input  logic             rxValid,
  output logic             lockFlag,
  output logic             errStrobe,
  output logic [CNT_W-1:0] errCount
);
  plcCtrl_t ctrl;
  logic     mismatch;
  logic     seedNonZero;
  logic     limitHit;

  plc_control #(.LFSR_LEN(LFSR_LEN)) u_control (
    .clk         (clk),
    .rst         (rst),
    .rxValid     (rxValid),
    .seedNonZero (seedNonZero),
    .limitHit    (limitHit),
    .ctrl        (ctrl),
    .lockFlag    (lockFlag)
  );

  plc_datapath #(
    .LFSR_LEN (LFSR_LEN),
    .TAP_HI   (TAP_HI),
    .TAP_LO   (TAP_LO),
    .CNT_W    (CNT_W)
  ) u_datapath (
    .clk         (clk),
    .rst         (rst),
    .rxBit       (rxBit),
    .ctrl        (ctrl),
    .mismatch    (mismatch),
    .seedNonZero (seedNonZero),
    .errStrobe   (errStrobe),
    .errCount    (errCount)
  );

  plc_window #(
    .WIN_LEN   (WIN_LEN),
    .ERR_LIMIT (ERR_LIMIT)
  ) u_window (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .mismatch (mismatch),
    .limitHit (limitHit)
  );
endmodule

// File: rtl/prbs_seed_checker_sva.sv
module prbs_seed_checker_sva #(
  parameter int LFSR_LEN = 7,
  parameter int CNT_W    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rxValid,
  input logic             lockFlag,
  input logic             errStrobe,
  input logic [CNT_W-1:0] errCount
);
  localparam int SC_W = $clog2(LFSR_LEN + 2);
  localparam logic [SC_W-1:0] SC_MAX = '1;

  // Valid bits seen since the lock flag was last low
  logic [SC_W-1:0] seenCnt;
  always_ff @(posedge clk) begin
    if (rst || lockFlag) begin
      seenCnt <= '0;
    end else if (rxValid && seenCnt != SC_MAX) begin
      seenCnt <= seenCnt + SC_W'(1);
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!lockFlag && !errStrobe && errCount == '0));

  p_lock_after_seed_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(lockFlag) |-> (seenCnt >= SC_W'(LFSR_LEN)));

  p_strobe_locked_r4: assert property (@(posedge clk) disable iff (rst)
    errStrobe |-> ($past(lockFlag) && $past(rxValid)));

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (errCount != $past(errCount)) |-> (errCount == $past(errCount) + CNT_W'(1)));

  p_count_sat_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(errCount) == '1) |-> (errCount == '1));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !rxValid |=> ($stable(lockFlag) && $stable(errCount) && !errStrobe));

  p_drop_on_error_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(lockFlag) |-> errStrobe);
endmodule

bind prbs_seed_checker prbs_seed_checker_sva #(
  .LFSR_LEN (LFSR_LEN),
  .CNT_W    (CNT_W)
) u_sva (
  .clk       (clk),
  .rst       (rst),
  .rxValid   (rxValid),
  .lockFlag  (lockFlag),
  .errStrobe (errStrobe),
  .errCount  (errCount)
);

// File: tb/prbs_seed_checker_bench.sv
module prbs_seed_checker_bench;
  localparam int CNT_W = 8;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxBit = 1'b0;
  logic rxValid = 1'b0;
  logic lockFlag;
  logic errStrobe;
  logic [CNT_W-1:0] errCount;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [6:0] txState;

  always #10 clk = ~clk;

  prbs_seed_checker #(.CNT_W(CNT_W)) u_prbs_seed_checker (
    .clk(clk), .rst(rst), .rxBit(rxBit), .rxValid(rxValid),
    .lockFlag(lockFlag), .errStrobe(errStrobe), .errCount(errCount)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one bit on the falling edge, return 2 ns after the rising edge
  task automatic drive(input logic b, input logic v);
    @(negedge clk);
    rxBit = b;
    rxValid = v;
    @(posedge clk);
    #2;
  endtask

  // Model generator x^7 + x^6 + 1: next bit = stage7 ^ stage6, into stage 1
  task automatic sendTx(input logic flip);
    logic b;
    b = txState[6] ^ txState[5];
    txState = {txState[5:0], b};
    drive(b ^ flip, 1'b1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    rxValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int errs;
    int strobes;
    int expCnt;
    // R1: reset state
    repeat (2) @(posedge clk);
    #2;
    chk("R1 lock after reset", lockFlag, 0);
    chk("R1 strobe after reset", errStrobe, 0);
    chk("R1 count after reset", errCount, 0);

    // R2, R3, R6: every start phase, with invalid gaps carrying garbage
    for (int v = 1; v < 128; v++) begin
      doReset();
      txState = 7'(v);
      strobes = 0;
      for (int k = 0; k < 7; k++) begin
        if (v % 3 == 0) begin
          drive(k[0], 1'b0);
          chk("R6 gap keeps lock low", lockFlag, 0);
        end
        sendTx(1'b0);
        if (k == 5) chk("R2 unlocked after six bits", lockFlag, 0);
      end
      chk("R2 locked after seventh bit", lockFlag, 1);
      for (int j = 0; j < 16; j++) begin
        sendTx(1'b0);
        strobes += int'(errStrobe);
      end
      chk("R3 no strobes on clean phase", strobes, 0);
      chk("R3 no count on clean phase", errCount, 0);
      chk("R3 lock held on clean phase", lockFlag, 1);
    end

    // R4, R5, R6, R10: isolated errors with gaps
    doReset();
    txState = 7'h40;
    for (int k = 0; k < 7; k++) sendTx(1'b0);
    expCnt = 0;
    for (int j = 0; j < 40; j++) begin
      logic f;
      f = (j == 10 || j == 30);
      sendTx(f);
      if (f) expCnt++;
      if (j == 11 || j == 31) chk("R10 bit after error clean", errStrobe, 0);
      else chk("R4 strobe tracks mismatch", errStrobe, int'(f));
      chk("R5 count increments", errCount, expCnt);
      if (j == 10) begin
        drive(1'b1, 1'b0);
        chk("R4 strobe is one cycle", errStrobe, 0);
        drive(1'b0, 1'b0);
        chk("R6 count held on gap", errCount, expCnt);
        chk("R6 lock held on gap", lockFlag, 1);
      end
    end

    // R7: spacing 19 never reaches the limit
    doReset();
    txState = 7'h11;
    for (int k = 0; k < 7; k++) sendTx(1'b0);
    errs = 0;
    for (int j = 0; j < 200; j++) begin
      sendTx(j % 19 == 0);
      if (j % 19 == 0) begin
        errs++;
        chk("R7 spacing 19 keeps lock", lockFlag, 1);
      end
    end
    chk("R7 spacing 19 count", errCount, errs);

    // R7, R8: spacing 18 drops lock at the eighth error, then relock
    doReset();
    txState = 7'h2B;
    for (int k = 0; k < 7; k++) sendTx(1'b0);
    errs = 0;
    for (int j = 0; j < 127; j++) begin
      sendTx(j % 18 == 0);
      if (j % 18 == 0) errs++;
      chk("R7 spacing 18 lock", lockFlag, (errs >= 8) ? 0 : 1);
    end
    chk("R7 strobe on dropping error", errStrobe, 1);
    chk("R7 eight errors counted", errCount, 8);
    for (int k = 0; k < 7; k++) begin
      sendTx(1'b0);
      if (k == 5) chk("R7 reseed unlocked after six", lockFlag, 0);
    end
    chk("R7 relock after seven", lockFlag, 1);
    chk("R8 count kept over reseed", errCount, 8);
    strobes = 0;
    for (int j = 0; j < 10; j++) begin
      sendTx(1'b0);
      strobes += int'(errStrobe);
    end
    chk("R7 clean after relock", strobes, 0);

    // R9: all-zero seed
    doReset();
    for (int k = 0; k < 7; k++) drive(1'b0, 1'b1);
    chk("R9 zero seed stays unlocked", lockFlag, 0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    chk("R9 still seeding on zeros", lockFlag, 0);
    drive(1'b1, 1'b1);
    chk("R9 locks on first non-zero", lockFlag, 1);
    txState = 7'h01;
    strobes = 0;
    for (int j = 0; j < 12; j++) begin
      sendTx(1'b0);
      strobes += int'(errStrobe);
    end
    chk("R9 tracks after zero seed", strobes, 0);

    // R5: saturation, with drops and reseeds on the way
    doReset();
    txState = 7'h40;
    for (int k = 0; k < 7; k++) sendTx(1'b0);
    errs = 0;
    expCnt = 0;
    while (errs < 270) begin
      if (lockFlag) begin
        sendTx(1'b1);
        errs++;
        if (expCnt < CNT_MAX) expCnt++;
        if (errs == CNT_MAX) chk("R5 count reaches max", errCount, CNT_MAX);
        if (errs == 260) chk("R4 strobe at saturated count", errStrobe, 1);
      end else begin
        sendTx(1'b0);
      end
    end
    chk("R5 count saturates", errCount, expCnt);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule